// File: doc/BRIEF.md
# Circular Ping-Pong Sample Buffer

This block takes one 16-bit converter result per sample strobe and turns the stream into writes to a circular memory of 120 entries. Each write goes to the next entry. After the last entry the address returns to entry 0, and this repeats with no end. The ring is split into a lower half (entries 0 to 59) and an upper half (entries 60 to 119). When the last entry of a half has been written, that half's done flag rises and `ready_base` names the first entry of the half that has just filled. A consumer can then read that half while the writer fills the other one. No processor work is needed per sample. At a nominal 480 samples per second, one half becomes ready every 1/8 s.

A small state machine tracks which half is being filled:
- `FILL_LO` moves to `FILL_HI` on the sample that lands in entry 59 (transition "lower half closes").
- `FILL_HI` moves back to `FILL_LO` on the sample that lands in entry 119 (transition "upper half closes, ring wraps").
- Reset enters `FILL_LO`.

Each half has:
- a sticky done flag, cleared by a write-one-to-clear pulse;
- an overrun bit, which latches when the half fills again before its flag was cleared;
- an interrupt gated by its own enable.

Nothing pushes back on the converter: every strobe is accepted.

Top module: `pingpong_ring`

## Requirements
- R1: While reset is held, and on the first cycle after it, `mem_we`, both done flags, both overrun bits and both interrupts are 0 and `ready_base` is 0. The first sample after reset is written to entry 0.
- R2: A sample presented with `smp_valid` high at a clock edge appears as `mem_we`=1, with `mem_wdata` equal to that sample, in the following cycle. `mem_we` is 0 in any cycle that follows a cycle without `smp_valid`. Samples on consecutive cycles are all accepted.
- R3: Successive writes use addresses that step by one from 0 up to 119 and then wrap to 0.
- R4: `lo_done` is 1 in the cycle after the cycle in which `mem_we` is 1 with `mem_addr` = 59.
- R5: `hi_done` is 1 in the cycle after the cycle in which `mem_we` is 1 with `mem_addr` = 119.
- R6: `ready_base` becomes 0 together with a lower-half event and 60 together with an upper-half event. It holds its value otherwise.
- R7: A done flag stays 1 until its clear input is 1 at a clock edge, and is 0 after that edge. If the clear and that half's event coincide, the flag is 1.
- R8: An event for a half while its flag is already 1 and its clear is 0 sets that half's overrun bit. The overrun bit stays set until the same clear input is pulsed, except that it is set again if a new overrun happens at that edge.
- R9: `lo_irq` equals `lo_done` AND `lo_ien`, and `hi_irq` equals `hi_done` AND `hi_ien`, within the same cycle. The two enables act independently.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_valid | input | 1 | Sample strobe from the converter |
| smp_data | input | 16 | Sample value |
| mem_we | output | 1 | Ring memory write enable |
| mem_addr | output | 7 | Ring memory write address |
| mem_wdata | output | 16 | Ring memory write data |
| lo_clr | input | 1 | Write-one-to-clear for the lower-half flag and its overrun bit |
| hi_clr | input | 1 | Write-one-to-clear for the upper-half flag and its overrun bit |
| lo_ien | input | 1 | Lower-half interrupt enable |
| hi_ien | input | 1 | Upper-half interrupt enable |
| lo_done | output | 1 | Lower half full (sticky) |
| hi_done | output | 1 | Upper half full (sticky) |
| lo_ovr | output | 1 | Lower half filled again before its flag was cleared |
| hi_ovr | output | 1 | Upper half filled again before its flag was cleared |
| lo_irq | output | 1 | Lower-half interrupt |
| hi_irq | output | 1 | Upper-half interrupt |
| ready_base | output | 7 | First entry of the half most recently filled |

## Verification
The memory write is due one cycle after the strobe edge. The done flags, overrun bits and `ready_base` are due one cycle after that, so two edges after the strobe that carried the closing sample. The interrupts follow the flags and enables in the same cycle. The bench keeps a cycle model that moves its write stage and its flag stage at the same edges as these registers. It drives inputs on the falling edge and compares every output on the next falling edge, so each result is read in exactly the cycle it is due.

// File: rtl/pp_pkg.sv
`timescale 1ns/1ps
package pp_pkg;

    // Which half of the ring the writer is currently filling.
    typedef enum logic {
        FILL_LO = 1'b0,
        FILL_HI = 1'b1
    } fill_state_e;

    // Index of each half inside the two-entry event and flag vectors.
    localparam int LO_IDX = 0;
    localparam int HI_IDX = 1;
    localparam int NUM_HALVES = 2;

endpackage

// File: rtl/ring_writer.sv
`timescale 1ns/1ps
// Turns sample strobes into ring writes; the state machine tracks the half being filled.
module ring_writer
    import pp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 120,
    localparam int HALF   = DEPTH / 2,
    localparam int OFF_W  = $clog2(HALF),
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);

    fill_state_e      state_q, state_d;
    logic [OFF_W-1:0] off_q, off_d;
    logic             last_in_half;
    logic [ADDR_W-1:0] half_base;
    logic [ADDR_W-1:0] cur_addr;

    assign last_in_half = (off_q == OFF_W'(HALF - 1));

    // Next-state logic: move to the other half when its last entry is taken.
    always_comb begin
        state_d = state_q;
        off_d   = off_q;
        if (smp_valid) begin
            if (last_in_half) begin
                off_d = '0;
                unique case (state_q)
                    FILL_LO: state_d = FILL_HI;
                    FILL_HI: state_d = FILL_LO;
                endcase
            end else begin
                off_d = off_q + 1'b1;
            end
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FILL_LO;
            off_q   <= '0;
        end else begin
            state_q <= state_d;
            off_q   <= off_d;
        end
    end

    // Address of the entry that the current sample lands in.
    always_comb begin
        unique case (state_q)
            FILL_LO: half_base = '0;
            FILL_HI: half_base = ADDR_W'(HALF);
        endcase
        cur_addr = half_base + ADDR_W'(off_q);
    end

    // Output register: the write is issued the cycle after the strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_en   <= 1'b0;
            wr_addr <= '0;
            wr_data <= '0;
        end else begin
            wr_en <= smp_valid;
            if (smp_valid) begin
                wr_addr <= cur_addr;
                wr_data <= smp_data;
            end
        end
    end

endmodule

// File: rtl/ready_tracker.sv
`timescale 1ns/1ps
// Detects the closing write of each half and publishes the base of the ready half.
module ready_tracker
    import pp_pkg::*;
#(
    parameter int DEPTH  = 120,
    localparam int HALF   = DEPTH / 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [ADDR_W-1:0]     wr_addr,
    output logic [NUM_HALVES-1:0] half_evt,
    output logic [ADDR_W-1:0]     ready_base
);

    assign half_evt[LO_IDX] = wr_en && (wr_addr == ADDR_W'(HALF - 1));
    assign half_evt[HI_IDX] = wr_en && (wr_addr == ADDR_W'(DEPTH - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ready_base <= '0;
        end else if (half_evt[HI_IDX]) begin
            ready_base <= ADDR_W'(HALF);
        end else if (half_evt[LO_IDX]) begin
            ready_base <= '0;
        end
    end

endmodule

// File: rtl/half_flag.sv
`timescale 1ns/1ps
// Sticky done flag with write-one-to-clear, overrun latch and gated interrupt.
module half_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic evt,
    input  logic clr,
    input  logic ien,
    output logic done,
    output logic ovr,
    output logic irq
);

    logic done_d, ovr_d, ovr_hit;

    assign ovr_hit = evt && done && !clr;

    // The event wins over a clear arriving at the same edge.
    always_comb begin
        done_d = evt | (done & ~clr);
        ovr_d  = ovr_hit | (ovr & ~clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done <= 1'b0;
            ovr  <= 1'b0;
        end else begin
            done <= done_d;
            ovr  <= ovr_d;
        end
    end

    assign irq = done & ien;

endmodule

// File: rtl/pingpong_ring.sv
`timescale 1ns/1ps
// Circular ping-pong sample buffer: top level.
module pingpong_ring
    import pp_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 120,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              smp_valid,
    input  logic [DATA_W-1:0] smp_data,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              lo_clr,
    input  logic              hi_clr,
    input  logic              lo_ien,
    input  logic              hi_ien,
    output logic              lo_done,
    output logic              hi_done,
    output logic              lo_ovr,
    output logic              hi_ovr,
    output logic              lo_irq,
    output logic              hi_irq,
    output logic [ADDR_W-1:0] ready_base
);

    logic [NUM_HALVES-1:0] half_evt;
    logic [NUM_HALVES-1:0] clr_v, ien_v, done_v, ovr_v, irq_v;

    ring_writer #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_writer (
        .clk      (clk),
        .rst_n    (rst_n),
        .smp_valid(smp_valid),
        .smp_data (smp_data),
        .wr_en    (mem_we),
        .wr_addr  (mem_addr),
        .wr_data  (mem_wdata)
    );

    ready_tracker #(.DEPTH(DEPTH)) u_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mem_we),
        .wr_addr   (mem_addr),
        .half_evt  (half_evt),
        .ready_base(ready_base)
    );

    assign clr_v[LO_IDX] = lo_clr;
    assign clr_v[HI_IDX] = hi_clr;
    assign ien_v[LO_IDX] = lo_ien;
    assign ien_v[HI_IDX] = hi_ien;

    for (genvar g = 0; g < NUM_HALVES; g++) begin : g_half
        half_flag u_flag (
            .clk  (clk),
            .rst_n(rst_n),
            .evt  (half_evt[g]),
            .clr  (clr_v[g]),
            .ien  (ien_v[g]),
            .done (done_v[g]),
            .ovr  (ovr_v[g]),
            .irq  (irq_v[g])
        );
    end

    assign lo_done = done_v[LO_IDX];
    assign hi_done = done_v[HI_IDX];
    assign lo_ovr  = ovr_v[LO_IDX];
    assign hi_ovr  = ovr_v[HI_IDX];
    assign lo_irq  = irq_v[LO_IDX];
    assign hi_irq  = irq_v[HI_IDX];

endmodule

// File: rtl/pingpong_ring_chk.sv
`timescale 1ns/1ps
// Port-level checker, attached to every pingpong_ring instance.
module pingpong_ring_chk #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 120,
    localparam int HALF   = DEPTH / 2,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              smp_valid,
    input logic [DATA_W-1:0] smp_data,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata,
    input logic              lo_clr,
    input logic              hi_clr,
    input logic              lo_done,
    input logic              hi_done,
    input logic              lo_ovr,
    input logic              hi_ovr,
    input logic [ADDR_W-1:0] ready_base
);

    logic              seen_wr;
    logic [ADDR_W-1:0] last_addr;
    logic [ADDR_W-1:0] exp_next;
    logic              lo_evt, hi_evt;

    assign lo_evt   = mem_we && (mem_addr == ADDR_W'(HALF - 1));
    assign hi_evt   = mem_we && (mem_addr == ADDR_W'(DEPTH - 1));
    assign exp_next = (last_addr == ADDR_W'(DEPTH - 1)) ? '0 : last_addr + 1'b1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seen_wr   <= 1'b0;
            last_addr <= '0;
        end else if (mem_we) begin
            seen_wr   <= 1'b1;
            last_addr <= mem_addr;
        end
    end

    // R1
    first_wr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && !seen_wr) |-> (mem_addr == '0));

    // R2
    wr_follows_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        smp_valid |=> (mem_we && mem_wdata == $past(smp_data)));

    // R2
    no_spurious_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !smp_valid |=> !mem_we);

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && seen_wr) |-> (mem_addr == exp_next));

    // R4
    lo_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_evt |=> lo_done);

    // R5
    hi_done_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_evt |=> hi_done);

    // R6
    base_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hi_evt |=> (ready_base == ADDR_W'(HALF)));

    // R6
    base_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
        lo_evt |=> (ready_base == '0));

    // R7
    lo_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_done && !lo_clr) |=> lo_done);

    // R7
    lo_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_clr && !lo_evt) |=> !lo_done);

    // R7
    hi_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_clr && !hi_evt) |=> !hi_done);

    // R8
    lo_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lo_evt && lo_done && !lo_clr) |=> lo_ovr);

    // R8
    hi_overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hi_evt && hi_done && !hi_clr) |=> hi_ovr);

endmodule

bind pingpong_ring pingpong_ring_chk #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/pingpong_ring_bench.sv
`timescale 1ns/1ps
module pingpong_ring_bench;

    localparam int DATA_W = 16;
    localparam int DEPTH  = 120;
    localparam int HALF   = DEPTH / 2;
    localparam int ADDR_W = $clog2(DEPTH);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              smp_valid = 1'b0;
    logic [DATA_W-1:0] smp_data = '0;
    logic              lo_clr = 1'b0, hi_clr = 1'b0, lo_ien = 1'b0, hi_ien = 1'b0;
    logic              mem_we, lo_done, hi_done, lo_ovr, hi_ovr, lo_irq, hi_irq;
    logic [ADDR_W-1:0] mem_addr, ready_base;
    logic [DATA_W-1:0] mem_wdata;

    always #2 clk = ~clk;

    pingpong_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_pingpong_ring (.*);

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    // Bench model of the block.
    logic        e_we = 0;
    int          e_addr = 0, e_data = 0, ptr = 0, e_base = 0;
    logic        e_lo = 0, e_hi = 0, e_lovr = 0, e_hovr = 0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int next_ptr(input int p);
        return (p == DEPTH - 1) ? 0 : p + 1;
    endfunction

    // Advance the model by one clock edge, with the inputs that were driven for it.
    task automatic model_edge(input logic v, input int d, input logic lc, input logic hc);
        logic ev_lo, ev_hi;
        ev_lo = e_we && (e_addr == HALF - 1);
        ev_hi = e_we && (e_addr == DEPTH - 1);
        e_lovr = (ev_lo && e_lo && !lc) || (e_lovr && !lc);
        e_hovr = (ev_hi && e_hi && !hc) || (e_hovr && !hc);
        e_lo = ev_lo || (e_lo && !lc);
        e_hi = ev_hi || (e_hi && !hc);
        if (ev_hi) e_base = HALF;
        else if (ev_lo) e_base = 0;
        e_we = v;
        if (v) begin
            e_addr = ptr;
            e_data = d;
            ptr = next_ptr(ptr);
        end
    endtask

    task automatic compare_all();
        chk("R2", "mem_we", int'(mem_we), int'(e_we));
        if (e_we) begin
            chk("R3", "mem_addr", int'(mem_addr), e_addr);
            chk("R2", "mem_wdata", int'(mem_wdata), e_data);
        end
        chk("R4", "lo_done", int'(lo_done), int'(e_lo));
        chk("R5", "hi_done", int'(hi_done), int'(e_hi));
        chk("R8", "lo_ovr", int'(lo_ovr), int'(e_lovr));
        chk("R8", "hi_ovr", int'(hi_ovr), int'(e_hovr));
        chk("R6", "ready_base", int'(ready_base), e_base);
        chk("R9", "lo_irq", int'(lo_irq), int'(e_lo && lo_ien));
        chk("R9", "hi_irq", int'(hi_irq), int'(e_hi && hi_ien));
    endtask

    // One cycle: drive at the falling edge, let the rising edge pass, compare at the next falling edge.
    task automatic cyc(input logic v, input int d, input logic lc, input logic hc);
        smp_valid = v;
        smp_data  = DATA_W'(d);
        lo_clr    = lc;
        hi_clr    = hc;
        @(posedge clk);
        model_edge(v, d, lc, hc);
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1", "mem_we in reset", int'(mem_we), 0);
        chk("R1", "lo_done in reset", int'(lo_done), 0);
        chk("R1", "hi_done in reset", int'(hi_done), 0);
        chk("R1", "ovr in reset", int'(lo_ovr | hi_ovr), 0);
        chk("R1", "ready_base in reset", int'(ready_base), 0);
        rst_n = 1'b1;
        lo_ien = 1'b1;
        // R1: the first sample lands in entry 0
        cyc(1'b1, 16'h1234, 1'b0, 1'b0);
        chk("R1", "first address", int'(mem_addr), 0);
        // Phase A: back-to-back samples with no clears, driving overruns (R2, R3, R4, R5, R8).
        for (int i = 0; i < 2 * DEPTH + 5; i++) cyc(1'b1, int'($urandom() & 16'hFFFF), 1'b0, 1'b0);
        chk("R8", "lo overrun after two rounds", int'(lo_ovr), 1);
        chk("R8", "hi overrun after two rounds", int'(hi_ovr), 1);
        // R7/R8: clear both flags and overruns
        cyc(1'b0, 0, 1'b1, 1'b1);
        chk("R7", "lo cleared", int'(lo_done), 0);
        chk("R8", "hi ovr cleared", int'(hi_ovr), 0);
        // Phase B: random strobes, clears and enables (R6, R7, R9).
        for (int i = 0; i < 3000; i++) begin
            if (($urandom() % 50) == 0) begin
                lo_ien = $urandom() % 2;
                hi_ien = $urandom() % 2;
            end
            cyc(($urandom() % 10) < 7, int'($urandom() & 16'hFFFF),
                ($urandom() % 20) == 0, ($urandom() % 20) == 0);
        end
        // Phase C: clears held high while streaming, so every event meets a clear (R7).
        for (int i = 0; i < DEPTH + 4; i++) cyc(1'b1, i * 7, 1'b1, 1'b1);
        // R6: stop exactly after the write to entry 59 or 119 and check the published base
        while (!(e_we && (e_addr == HALF - 1))) cyc(1'b1, 5, 1'b0, 1'b0);
        cyc(1'b0, 0, 1'b0, 1'b0);
        chk("R6", "base after lower half", int'(ready_base), 0);
        chk("R4", "lo_done after lower half", int'(lo_done), 1);
        while (!(e_we && (e_addr == DEPTH - 1))) cyc(1'b1, 9, 1'b0, 1'b0);
        cyc(1'b0, 0, 1'b0, 1'b0);
        chk("R6", "base after upper half", int'(ready_base), HALF);
        chk("R5", "hi_done after upper half", int'(hi_done), 1);
        // R9: enables gate the interrupt independently
        lo_ien = 1'b0; hi_ien = 1'b1;
        @(negedge clk);
        chk("R9", "lo_irq masked", int'(lo_irq), 0);
        chk("R9", "hi_irq enabled", int'(hi_irq), int'(hi_done));
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired before the run ended");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule